// File: doc/BRIEF.md
# Prioritised Change-of-State / Level Interrupt Controller

This block watches eight asynchronous digital inputs and turns selected activity on them into one active-high interrupt request. Each channel is set either to trigger on any transition or to trigger while its level equals a programmed polarity. Each channel has an enable bit, a mode bit, a polarity bit and a sticky status flag. Software clears a status flag by writing 1 to its bit. A shared 8-bit vector register supplies the upper five bits of the acknowledge vector. The low three bits are always the number of the channel being served.

The inputs pass through a two-flop synchroniser. A per-channel detector compares the synchronised value with its copy from one clock earlier, or with the polarity bit. An enabled hit sets the status flag. An arbiter state machine raises the request and always presents the highest-numbered pending channel. It answers an acknowledge strobe by driving the vector. The state machine has three states:
- **IDLE**: no request.
- **REQ**: request asserted; the presented channel follows the highest pending channel.
- **ACK**: the vector is driven; the presented channel is frozen.

The transitions are:
- IDLE → REQ when any enabled channel will be pending after this edge.
- REQ → ACK when the select strobe is high and the line-select bit is low.
- ACK → REQ when the strobe drops.
- REQ → IDLE and ACK → IDLE when the presented channel stops being pending, because it was cleared or disabled.

Registers are written through a write-enable, a 3-bit select and a data byte.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable, mode, polarity, status and vector registers are all 0. `irq_o` is 0, `vec_vld_o` is 0 and `vec_o` is 0.
- R2: With mode bit 1 (select code 1) on an enabled channel, any transition of the synchronised input sets that channel's status bit. The polarity register (select code 2) has no effect on such a channel, so a steady input leaves the status bit at 0.
- R3: With mode bit 0 on an enabled channel, the status bit is set while the synchronised input equals the polarity bit. Polarity 0 means low and polarity 1 means high.
- R4: A channel whose enable bit is 0 (select code 0) never sets its status bit. A status bit that is already set on a disabled channel is kept, but it produces no request: `irq_o` falls within two cycles after the enable is cleared.
- R5: A write with select code 3 clears every status bit whose data bit is 1. The clear takes priority over a hit in the same cycle. If the level condition still holds, the bit sets again on the following edge and the request returns one cycle later. `irq_o` is low for exactly one cycle.
- R6: `irq_o` is high only while some enabled status bit is pending. Of the pending channels, the highest-numbered one (channel 7 first) is presented.
- R7: When the select strobe is high with line-select 0 during a request, the next cycle has `vec_vld_o`=1 and `vec_o` = {vector[7:3], channel[2:0]}. Bits 2:0 written to the vector register (select code 4) are ignored. With line-select 1 no vector is driven. When `vec_vld_o` is 0, `vec_o` reads 0.
- R8: An input change sampled at rising edge k raises `irq_o` after edge k+2. This is 2 to 3 clock periods from an asynchronous change.
- R9: When the presented channel is cleared while another channel is pending, `irq_o` drops for one cycle and then re-asserts, presenting the next-highest pending channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | 8 | Asynchronous digital inputs, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 enable, 1 mode, 2 polarity, 3 status clear, 4 vector |
| wr_data_i | input | 8 | Write data |
| int_sel_i | input | 1 | Interrupt acknowledge select strobe |
| ack_a1_i | input | 1 | Request line select: 0 is this line, 1 is the unused second line |
| irq_o | output | 1 | Interrupt request, active high |
| vec_vld_o | output | 1 | Vector is being driven |
| vec_o | output | 8 | Acknowledge vector |
| status_o | output | 8 | Per-channel status flags |

## Verification
The bench goes after the following corner cases, and says what a wrong design would do in each:
- **Clear versus re-latch.** A clear written while a level condition still holds must drop the request for exactly one cycle. A design that lets the set win would never release the line. A design that forgets to re-latch would lose the event.
- **Polarity on a transition channel.** Holding an input steady at the polarity level on a change-of-state channel must stay silent. A design that leaks polarity into that mode would raise a request.
- **Disabling with a flag already set.** A design that kept requesting would show `irq_o` high.
- **Acknowledge on the wrong line.** A design that ignores line-select would drive a vector.
- **Priority and latency.** Random channel mixes with simultaneous events check that the highest channel's number lands in the vector's low bits. Sampling right around the synchroniser delay catches an extra or a missing flop.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_MODE   = 3'd1,
        SEL_POLAR  = 3'd2,
        SEL_CLEAR  = 3'd3,
        SEL_VECTOR = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int NCH    = 8,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] async_i,
    output logic [NCH-1:0] sync_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sync_i,
    input  logic [NCH-1:0] mode_i,
    input  logic [NCH-1:0] polar_i,
    input  logic [NCH-1:0] enable_i,
    input  logic [NCH-1:0] clear_i,
    output logic [NCH-1:0] status_o,
    output logic [NCH-1:0] status_nxt_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic prev_q;
        logic flag_q;
        logic hit;
        logic flag_n;

        // mode 1: any transition; mode 0: level equals polarity
        always_comb begin
            if (mode_i[g]) hit = sync_i[g] ^ prev_q;
            else           hit = (sync_i[g] == polar_i[g]);
            // a clear outranks a hit in the same cycle
            if (clear_i[g]) flag_n = 1'b0;
            else            flag_n = flag_q | (enable_i[g] & hit);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                prev_q <= sync_i[g];
                flag_q <= flag_n;
            end
        end

        assign status_o[g]     = flag_q;
        assign status_nxt_o[g] = flag_n;

        // R4: a disabled, idle channel stays idle
        assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable_i[g] && !flag_q) |=> !flag_q);

        // R5: a written clear always takes effect on that edge
        assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i[g] |=> !flag_q);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_nxt_i,
    input  logic           sel_i,
    input  logic           a1_i,
    output logic           irq_o,
    output logic           vld_o,
    output logic [CW-1:0]  chan_o
);

    arb_state_e     state_q, state_n;
    logic [CW-1:0]  chan_q, chan_n;
    logic [NCH-1:0] pend_q;

    function automatic logic [CW-1:0] top_of(input logic [NCH-1:0] v);
        top_of = '0;
        for (int i = 0; i < NCH; i++) begin
            if (v[i]) top_of = CW'(i);
        end
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_n;
            chan_q  <= chan_n;
            pend_q  <= pend_nxt_i;
        end
    end

    always_comb begin
        state_n = state_q;
        chan_n  = chan_q;
        unique case (state_q)
            ST_IDLE: begin
                if (|pend_nxt_i) begin
                    state_n = ST_REQ;
                    chan_n  = top_of(pend_nxt_i);
                end
            end
            ST_REQ: begin
                if (!pend_nxt_i[chan_q]) begin
                    state_n = ST_IDLE;
                end else if (sel_i && !a1_i) begin
                    state_n = ST_ACK;
                end else begin
                    chan_n = top_of(pend_nxt_i);
                end
            end
            ST_ACK: begin
                if (!pend_nxt_i[chan_q]) begin
                    state_n = ST_IDLE;
                end else if (!sel_i) begin
                    state_n = ST_REQ;
                    chan_n  = top_of(pend_nxt_i);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o  = (state_q != ST_IDLE);
        vld_o  = (state_q == ST_ACK);
        chan_o = chan_q;
    end

    // R6: the request is backed by a pending channel
    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q != '0));

    // R6: nothing above the presented channel is pending while requesting
    assert_top_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ) |-> ((pend_q >> chan_q) == NCH'(1)));

    // R7: an acknowledged channel is still pending
    assert_ack_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |-> pend_q[chan_q]);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int DW          = 8,
    parameter int VW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din_i,
    input  logic           wr_en_i,
    input  logic [2:0]     wr_sel_i,
    input  logic [DW-1:0]  wr_data_i,
    input  logic           int_sel_i,
    input  logic           ack_a1_i,
    output logic           irq_o,
    output logic           vec_vld_o,
    output logic [VW-1:0]  vec_o,
    output logic [NCH-1:0] status_o
);

    localparam int CW = $clog2(NCH);
    localparam int HW = VW - CW;

    logic [NCH-1:0] enable_q, mode_q, polar_q;
    logic [HW-1:0]  vhi_q;
    logic [NCH-1:0] din_sync, status_nxt, clear_mask, pend_nxt;
    logic [CW-1:0]  chan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            mode_q   <= '0;
            polar_q  <= '0;
            vhi_q    <= '0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_ENABLE: enable_q <= wr_data_i[NCH-1:0];
                SEL_MODE:   mode_q   <= wr_data_i[NCH-1:0];
                SEL_POLAR:  polar_q  <= wr_data_i[NCH-1:0];
                SEL_VECTOR: vhi_q    <= wr_data_i[VW-1:CW];
                default:    ;
            endcase
        end
    end

    always_comb begin
        clear_mask = (wr_en_i && wr_sel_i == SEL_CLEAR) ? wr_data_i[NCH-1:0] : '0;
        pend_nxt   = status_nxt & enable_q;
    end

    irq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (din_i),
        .sync_o  (din_sync)
    );

    irq_detect #(.NCH(NCH)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (din_sync),
        .mode_i       (mode_q),
        .polar_i      (polar_q),
        .enable_i     (enable_q),
        .clear_i      (clear_mask),
        .status_o     (status_o),
        .status_nxt_o (status_nxt)
    );

    irq_arbiter #(.NCH(NCH), .CW(CW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_nxt_i (pend_nxt),
        .sel_i      (int_sel_i),
        .a1_i       (ack_a1_i),
        .irq_o      (irq_o),
        .vld_o      (vec_vld_o),
        .chan_o     (chan)
    );

    assign vec_o = vec_vld_o ? {vhi_q, chan} : '0;

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       int_sel = 1'b0;
    logic       ack_a1 = 1'b0;
    logic       irq;
    logic       vec_vld;
    logic [7:0] vec;
    logic [7:0] status;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_i     (din),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .int_sel_i (int_sel),
        .ack_a1_i  (ack_a1),
        .irq_o     (irq),
        .vec_vld_o (vec_vld),
        .vec_o     (vec),
        .status_o  (status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_stat(input logic [7:0] en, input logic [7:0] typ,
                                            input logic [7:0] pol, input logic [7:0] old,
                                            input logic [7:0] nw);
        exp_stat = en & ((typ & (old ^ nw)) | (~typ & (~(old ^ pol) | ~(nw ^ pol))));
    endfunction

    function automatic logic [2:0] top_idx(input logic [7:0] v);
        top_idx = 3'd0;
        for (int i = 0; i < 8; i++) if (v[i]) top_idx = 3'(i);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog (all requirements) act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rt, rp, rv, re, old, t, ex;
        void'($urandom(32'd13));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 vld", vec_vld, 0);
        chk("R1 vec", vec, 8'h00);

        // R4 disabled channel with level condition true
        din = 8'hFF;
        wr(3'd2, 8'hFF);
        tick(5);
        chk("R4 disabled status", status, 8'h00);
        chk("R4 disabled irq", irq, 0);

        // R3 level-low on channel 3, R8 latency
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h08);
        tick(3);
        chk("R3 level not met", status, 8'h00);
        din = 8'hF7;
        tick(1);
        chk("R8 irq after 1 edge", irq, 0);
        tick(1);
        chk("R8 irq after 2 edges", irq, 0);
        tick(1);
        chk("R8 irq after 3 edges", irq, 1);
        chk("R3 level low status", status, 8'h08);

        // R5 clear while level holds
        wr(3'd3, 8'h08);
        chk("R5 status cleared", status, 8'h00);
        chk("R5 irq gap", irq, 0);
        tick(1);
        chk("R5 status re-latched", status, 8'h08);
        chk("R5 irq back", irq, 1);

        // R4 disable with flag set
        wr(3'd0, 8'h00);
        tick(1);
        chk("R4 masked irq", irq, 0);
        chk("R4 flag kept", status, 8'h08);
        wr(3'd3, 8'hFF);
        chk("R5 clear all", status, 8'h00);

        // R2 transition mode ignores polarity
        wr(3'd1, 8'h30);
        wr(3'd2, 8'h10);
        wr(3'd4, 8'hAF);
        wr(3'd0, 8'h30);
        tick(4);
        chk("R2 steady input no event", status, 8'h00);
        chk("R2 steady irq", irq, 0);
        din = 8'hC7;
        tick(3);
        chk("R2 both toggled", status, 8'h30);
        chk("R2 irq", irq, 1);

        // R7 wrong line then right line
        int_sel = 1'b1; ack_a1 = 1'b1;
        tick(2);
        chk("R7 a1 high no vector", vec_vld, 0);
        chk("R7 a1 high vec zero", vec, 8'h00);
        ack_a1 = 1'b0;
        tick(1);
        chk("R7 vld", vec_vld, 1);
        chk("R7 R6 vector ch5", vec, 8'hAD);
        int_sel = 1'b0;
        tick(1);
        chk("R7 vld released", vec_vld, 0);
        chk("R6 irq held", irq, 1);

        // R9 clear served channel, next one follows
        wr(3'd3, 8'h20);
        chk("R9 irq gap", irq, 0);
        chk("R9 status left", status, 8'h10);
        tick(1);
        chk("R9 irq reassert", irq, 1);
        int_sel = 1'b1;
        tick(1);
        chk("R9 vector ch4", vec, 8'hAC);
        int_sel = 1'b0;
        tick(1);

        // random mixes: R2 R3 R6 R7
        for (int it = 0; it < 40; it++) begin
            rt = 8'($urandom); rp = 8'($urandom); rv = 8'($urandom);
            re = 8'($urandom); old = 8'($urandom); t = 8'($urandom);
            wr(3'd0, 8'h00);
            wr(3'd3, 8'hFF);
            din = old;
            tick(4);
            wr(3'd1, rt);
            wr(3'd2, rp);
            wr(3'd4, rv);
            wr(3'd0, re);
            tick(2);
            wr(3'd3, 8'hFF);
            tick(3);
            din = old ^ t;
            tick(5);
            ex = exp_stat(re, rt, rp, old, old ^ t);
            chk("R2 R3 random status", status, ex);
            chk("R6 random irq", irq, (ex != 8'h00));
            int_sel = 1'b1; ack_a1 = 1'b0;
            tick(1);
            chk("R7 random vld", vec_vld, (ex != 8'h00));
            chk("R6 R7 random vector", vec, (ex != 8'h00) ? {rv[7:3], top_idx(ex)} : 8'h00);
            int_sel = 1'b0;
            tick(1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule